// File: doc/BRIEF.md
# Accumulator ALU with Packed Condition Flags

This block is an 8-bit arithmetic and logic unit with its own accumulator register and a packed condition-flag byte. Each clock cycle where `loadEn` is high, the block applies the operation chosen by `opCode` to the accumulator and the `operand` byte. It then writes back the result, the flags, or both. The operation set is:

- add, add with carry
- subtract, subtract with borrow
- compare
- AND, OR, XOR
- increment, decrement
- a plain load of the operand into the accumulator

Five condition flags are kept: sign, zero, auxiliary carry (the carry out of bit 3), even parity and carry. They sit at fixed positions in one byte, so a neighbouring block can decode them directly. The remaining three bits of that byte are always zero.

Instruction decoding, the general register file and memory sit outside this block. A sequencer drives `opCode`, `operand` and `loadEn`. It reads back `accOut` and `flagOut`, both of which are registered.

Top module: `aluFlagUnit`

## Requirements
- R1: While `rstN` is low, the accumulator and the flag byte are 00h. Both are still 00h after reset is released, until the first enabled operation.
- R2: The flag byte layout is: bit 7 sign, bit 6 zero, bit 4 auxiliary carry, bit 2 parity, bit 0 carry. Bits 5, 3 and 1 always read 0.
- R3: Opcode 0 (ADD) loads A+B and opcode 1 (ADC) loads A+B+CY. Carry is set when the true sum exceeds FFh. Auxiliary carry is the carry out of bit 3 of the same addition.
- R4: Opcode 2 (SUB) loads A-B and opcode 3 (SBB) loads A-B-CY. Carry is set as a borrow when the minuend is less than the subtrahend plus the borrow-in. Auxiliary carry is the carry out of bit 3 of A + ~B + (1 - borrow-in).
- R5: Opcode 4 (CMP) sets every flag exactly as SUB would and leaves the accumulator unchanged.
- R6: Opcodes 5, 6 and 7 (AND, OR, XOR) load the bitwise result and clear carry. Auxiliary carry becomes 1 after AND and 0 after OR or XOR.
- R7: Opcode 8 (INC) loads A+1 and opcode 9 (DEC) loads A-1. Sign, zero, parity and auxiliary carry are updated (auxiliary carry is the bit-3 carry of A+01h or of A+FFh). Carry keeps its previous value.
- R8: Opcode 10 (LOAD) copies the operand into the accumulator and leaves the flag byte unchanged.
- R9: When `loadEn` is low, or the opcode is 11 to 15, neither the accumulator nor the flag byte changes.
- R10: For every flag-writing operation, sign copies bit 7 of the result, zero is set only for a 00h result, and parity is set for an even number of ones. For example, 30h-40h gives F0h with sign set, and 05h gives parity 1.
- R11: Results and flags appear on `accOut` and `flagOut` on the clock edge that samples the enabled operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Executes the operation on this edge when high |
| opCode | input | 4 | Operation select (encodings in R3 to R9) |
| operand | input | 8 | Second operand byte |
| accOut | output | 8 | Accumulator value |
| flagOut | output | 8 | Packed condition flag byte |

## Verification
The bench targets the following corner cases:

- **Borrow polarity in subtraction and in subtract-with-borrow.** Inverting it would show carry set on 16h-16h, or would subtract one too many in SBB.
- **The auxiliary-carry rule for subtraction.** A design that took the bit-3 carry of a plain difference would miss the flag on 30h-40h.
- **Carry preservation across increment and decrement with carry already set.** A design that cleared it would show carry 0 after DEC of 00h.
- **Compare and the undefined opcodes.** These check that the accumulator holds its value, since a design that wrote back the difference would expose a changed `accOut` on the next cycle.
- **The always-zero flag bits.**
- **The all-ones and zero wrap cases of add and increment.**

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC  = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
  localparam logic [OP_W-1:0] OP_SBB  = 4'd3;
  localparam logic [OP_W-1:0] OP_CMP  = 4'd4;
  localparam logic [OP_W-1:0] OP_AND  = 4'd5;
  localparam logic [OP_W-1:0] OP_OR   = 4'd6;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd7;
  localparam logic [OP_W-1:0] OP_INC  = 4'd8;
  localparam logic [OP_W-1:0] OP_DEC  = 4'd9;
  localparam logic [OP_W-1:0] OP_LOAD = 4'd10;

  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_AC = 4;
  localparam int FLAG_P  = 2;
  localparam int FLAG_CY = 0;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CY   = 2'd2,
    CIN_NCY  = 2'd3
  } cinSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic      writeAcc;
    logic      writeFlags;
    logic      holdCarry;
    logic      invB;
    logic      constOne;
    logic      borrowOut;
    logic      useLogic;
    logic      passOperand;
    logicSel_e logicSel;
    cinSel_e   cinSel;
  } aluCtrl_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic            loadEn,
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{writeAcc: 1'b0, writeFlags: 1'b0, holdCarry: 1'b0, invB: 1'b0,
             constOne: 1'b0, borrowOut: 1'b0, useLogic: 1'b0, passOperand: 1'b0,
             logicSel: LOG_AND, cinSel: CIN_ZERO};
    if (loadEn) begin
      unique case (opCode)
        OP_ADD: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1;
        end
        OP_ADC: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.cinSel = CIN_CY;
        end
        OP_SUB: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.invB = 1'b1;
          ctrl.borrowOut = 1'b1; ctrl.cinSel = CIN_ONE;
        end
        OP_SBB: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.invB = 1'b1;
          ctrl.borrowOut = 1'b1; ctrl.cinSel = CIN_NCY;
        end
        OP_CMP: begin
          ctrl.writeFlags = 1'b1; ctrl.invB = 1'b1;
          ctrl.borrowOut = 1'b1; ctrl.cinSel = CIN_ONE;
        end
        OP_AND: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.useLogic = 1'b1;
          ctrl.logicSel = LOG_AND;
        end
        OP_OR: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.useLogic = 1'b1;
          ctrl.logicSel = LOG_OR;
        end
        OP_XOR: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.useLogic = 1'b1;
          ctrl.logicSel = LOG_XOR;
        end
        OP_INC: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.holdCarry = 1'b1;
          ctrl.constOne = 1'b1;
        end
        OP_DEC: begin
          ctrl.writeAcc = 1'b1; ctrl.writeFlags = 1'b1; ctrl.holdCarry = 1'b1;
          ctrl.constOne = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
        end
        OP_LOAD: begin
          ctrl.writeAcc = 1'b1; ctrl.passOperand = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] accOut,
  output logic [7:0]       flagOut
);

  localparam int HALF = 4;

  logic [WIDTH-1:0] accReg;
  logic [7:0]       flagReg;

  logic [WIDTH-1:0] addB;
  logic             carryIn;
  logic [WIDTH:0]   fullSum;
  logic [HALF:0]    lowSum;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] result;
  logic             nextAc;
  logic             nextCy;
  logic [7:0]       nextFlags;

  always_comb begin
    addB = ctrl.constOne ? WIDTH'(1) : operand;
    if (ctrl.invB) addB = ~addB;
    unique case (ctrl.cinSel)
      CIN_ZERO: carryIn = 1'b0;
      CIN_ONE:  carryIn = 1'b1;
      CIN_CY:   carryIn = flagReg[FLAG_CY];
      default:  carryIn = ~flagReg[FLAG_CY];
    endcase
    fullSum = {1'b0, accReg} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn};
    lowSum  = {1'b0, accReg[HALF-1:0]} + {1'b0, addB[HALF-1:0]} + {{HALF{1'b0}}, carryIn};
  end

  always_comb begin
    unique case (ctrl.logicSel)
      LOG_AND: logicRes = accReg & operand;
      LOG_OR:  logicRes = accReg | operand;
      default: logicRes = accReg ^ operand;
    endcase
  end

  always_comb begin
    if (ctrl.passOperand)   result = operand;
    else if (ctrl.useLogic) result = logicRes;
    else                    result = fullSum[WIDTH-1:0];

    if (ctrl.useLogic) begin
      nextAc = (ctrl.logicSel == LOG_AND);
      nextCy = 1'b0;
    end else begin
      nextAc = lowSum[HALF];
      if (ctrl.holdCarry)      nextCy = flagReg[FLAG_CY];
      else if (ctrl.borrowOut) nextCy = ~fullSum[WIDTH];
      else                     nextCy = fullSum[WIDTH];
    end

    nextFlags          = 8'h00;
    nextFlags[FLAG_S]  = result[WIDTH-1];
    nextFlags[FLAG_Z]  = (result == '0);
    nextFlags[FLAG_AC] = nextAc;
    nextFlags[FLAG_P]  = ~^result;
    nextFlags[FLAG_CY] = nextCy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      flagReg <= 8'h00;
    end else begin
      if (ctrl.writeAcc)   accReg  <= result;
      if (ctrl.writeFlags) flagReg <= nextFlags;
    end
  end

  assign accOut  = accReg;
  assign flagOut = flagReg;

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg[5] == 1'b0) && (flagReg[3] == 1'b0) && (flagReg[1] == 1'b0));

  assert_flags_track_acc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeAcc && ctrl.writeFlags) |=>
      (flagReg[FLAG_S] == accReg[WIDTH-1]) && (flagReg[FLAG_Z] == (accReg == '0)) &&
      (flagReg[FLAG_P] == ~^accReg));

  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeFlags && !ctrl.writeAcc) |=> $stable(accReg));

  assert_carry_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdCarry |=> (flagReg[FLAG_CY] == $past(flagReg[FLAG_CY])));

  assert_logic_clears_cy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.useLogic && ctrl.writeFlags) |=> (flagReg[FLAG_CY] == 1'b0));

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.writeAcc && !ctrl.writeFlags) |=> ($stable(accReg) && $stable(flagReg)));

  assert_load_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.passOperand |=> ($stable(flagReg) && (accReg == $past(operand))));

endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic [3:0]  opCode,
  input  logic [7:0]  operand,
  output logic [7:0]  accOut,
  output logic [7:0]  flagOut
);

  aluCtrl_t ctrl;

  aluControl uControl (
    .loadEn (loadEn),
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  aluDatapath #(.WIDTH(DATA_W)) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .operand (operand),
    .accOut  (accOut),
    .flagOut (flagOut)
  );

endmodule

// File: tb/tb_aluFlagUnit.sv
module tb_aluFlagUnit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] accOut;
  logic [7:0] flagOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aluFlagUnit dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .opCode(opCode),
    .operand(operand), .accOut(accOut), .flagOut(flagOut)
  );

  // {opCode, operand, expected acc, expected flags}, applied in order from reset
  localparam int NVEC = 20;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd10, 8'h30, 8'h30, 8'h00},  // R8 load
    {4'd2,  8'h40, 8'hF0, 8'h95},  // R4 R10 30-40
    {4'd0,  8'h20, 8'h10, 8'h01},  // R3 add overflow
    {4'd1,  8'h05, 8'h16, 8'h00},  // R3 adc with CY
    {4'd4,  8'h16, 8'h16, 8'h54},  // R5 compare equal
    {4'd3,  8'h20, 8'hF6, 8'h95},  // R4 sbb no borrow-in
    {4'd3,  8'h06, 8'hEF, 8'h80},  // R4 sbb with borrow-in
    {4'd5,  8'h0F, 8'h0F, 8'h14},  // R6 and
    {4'd8,  8'h00, 8'h10, 8'h10},  // R7 inc nibble carry
    {4'd9,  8'h00, 8'h0F, 8'h04},  // R7 dec
    {4'd7,  8'hFF, 8'hF0, 8'h84},  // R6 xor
    {4'd6,  8'h0F, 8'hFF, 8'h84},  // R6 or
    {4'd8,  8'h00, 8'h00, 8'h54},  // R7 inc wrap
    {4'd9,  8'h00, 8'hFF, 8'h84},  // R7 dec wrap
    {4'd0,  8'h01, 8'h00, 8'h55},  // R3 add to zero
    {4'd9,  8'h00, 8'hFF, 8'h85},  // R7 carry held at 1
    {4'd10, 8'h05, 8'h05, 8'h85},  // R8 flags unchanged
    {4'd6,  8'h00, 8'h05, 8'h04},  // R10 parity of 05
    {4'd12, 8'h77, 8'h05, 8'h04},  // R9 unused code
    {4'd7,  8'h05, 8'h00, 8'h44}   // R10 zero
  };

  task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic applyOp(input logic en, input logic [3:0] op, input logic [7:0] b);
    @(negedge clk);
    loadEn = en; opCode = op; operand = b;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // reference model of ADD and SUB from R3/R4/R10
  function automatic logic [15:0] refAddSub(input logic [7:0] a, input logic [7:0] b,
                                            input logic isSub);
    logic [8:0] s;
    logic [4:0] lo;
    logic [7:0] f;
    logic [7:0] bb;
    bb = isSub ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + {8'd0, isSub};
    lo = {1'b0, a[3:0]} + {1'b0, bb[3:0]} + {4'd0, isSub};
    f = 8'h00;
    f[7] = s[7];
    f[6] = (s[7:0] == 8'h00);
    f[4] = lo[4];
    f[2] = ~^s[7:0];
    f[0] = isSub ? (a < b) : s[8];
    return {s[7:0], f};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 acc in reset", accOut, 8'h00);
    check8("R1 flags in reset", flagOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check8("R1 acc after release", accOut, 8'h00);
    check8("R1 flags after release", flagOut, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      applyOp(1'b1, VEC[i][27:24], VEC[i][23:16]);
      check8($sformatf("R11 vec%0d acc", i), accOut, VEC[i][15:8]);
      check8($sformatf("R2 vec%0d flags", i), flagOut, VEC[i][7:0]);
    end

    // R9: disabled enable leaves state alone
    applyOp(1'b0, 4'd0, 8'h33);
    check8("R9 loadEn low acc", accOut, 8'h00);
    check8("R9 loadEn low flags", flagOut, 8'h44);
    for (int op = 11; op < 16; op++) begin
      applyOp(1'b1, 4'(op), 8'hA5);
      check8("R9 unused opcode acc", accOut, 8'h00);
      check8("R9 unused opcode flags", flagOut, 8'h44);
    end

    // R3 R4 sweep against model
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      logic [15:0] exp;
      a = 8'(k * 37 + 9);
      b = 8'(k * 53 + 200);
      applyOp(1'b1, 4'd10, a);
      applyOp(1'b1, 4'd0, b);
      exp = refAddSub(a, b, 1'b0);
      check8("R3 sweep add acc", accOut, exp[15:8]);
      check8("R3 sweep add flags", flagOut, exp[7:0]);
      applyOp(1'b1, 4'd10, a);
      applyOp(1'b1, 4'd2, b);
      exp = refAddSub(a, b, 1'b1);
      check8("R4 sweep sub acc", accOut, exp[15:8]);
      check8("R4 sweep sub flags", flagOut, exp[7:0]);
      applyOp(1'b1, 4'd4, 8'(b + 8'd1));
      exp = refAddSub(exp[15:8], 8'(b + 8'd1), 1'b1);
      check8("R5 sweep cmp flags", flagOut, exp[7:0]);
      check8("R5 sweep cmp acc", accOut, refAddSub(a, b, 1'b1) >> 8);
    end

    // R1: reset mid-run
    applyOp(1'b1, 4'd10, 8'hC3);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check8("R1 acc after mid reset", accOut, 8'h00);
    check8("R1 flags after mid reset", flagOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule